// File: doc/BRIEF.md
# Elapsed-Time Event Logging Controller

This block timestamps asynchronous events for a logger. An event mission starts once: the wall-clock time is copied into a start stamp and a 16-bit elapsed-time counter begins to run. Every later qualifying event stores the counter's value, not a full time, as two bytes in a byte-wide log memory, then clears the counter. To rebuild the absolute time of each event, take the start stamp and add the stored intervals in order.

The surrounding chip supplies four things: a synchronized event level, a one-per-second tick, the current time/date as a flat bus, and single-cycle command strobes decoded from its register file. The strobes are arm, start, clear and "any other write". The controller drives the write port of the log RAM. It also drives the start stamp, a 24-bit event count, the live elapsed count, the log write pointer and three status flags: armed, active and memory-cleared. A mission can only begin from a freshly cleared log. It can begin on the first event (arm) or at once (start). Any register write ends it, but only after a log entry that is already being written has been completed.

Top module: `evt_elapsed_logger`

## Requirements
- R1: Edge select `trig_sel`: bit 0 set qualifies falling edges of the filtered event, bit 1 set qualifies rising edges, and 2'b11 qualifies both. An edge that is not selected changes nothing.
- R2: With `trig_sel` = 2'b00, event toggles have no effect, and arm and start commands are refused.
- R3: `res_sel` selects how often the elapsed count advances: 0 on every tick, 1 once every SEC_PER_MIN ticks, 2 or 3 once every SEC_PER_MIN*MIN_PER_HR ticks. These dividers restart at each mission start and at each logged event.
- R4: The elapsed count advances only while `mission_active` is 1. It stops at FFFFh instead of wrapping.
- R5: A logged event writes the elapsed count's low byte at `log_ptr` (an even address). On the next cycle it writes the high byte at `log_ptr`+1. It then adds 2 to `log_ptr`, increments `evt_count` and clears the elapsed count.
- R6: The pointer wraps from the last log address to 0, so the next event overwrites the oldest entry.
- R7: Delayed start: `cmd_arm` sets `mission_armed`. The first qualifying event then sets `mission_active`, copies `now_stamp` to `start_stamp`, sets `evt_count` to 1 and starts the elapsed count. It writes nothing to the log.
- R8: Immediate start: `cmd_start` sets both `mission_armed` and `mission_active`, copies `now_stamp`, sets `evt_count` to 1 and starts the elapsed count. The first event then logs the time since the start.
- R9: Arm and start are accepted only while `mem_cleared` is 1. `mem_cleared` is 0 out of reset.
- R10: `cmd_clear` is honoured only while the block is neither armed nor active. It writes 00h to every log address in ascending order, one per cycle, and zeroes the count, pointer, stamp and elapsed count. It then sets `mem_cleared`, which drops again on the first log write of a mission.
- R11: `cmd_write` ends a mission, dropping armed and active. If it arrives while an event is being recorded, both bytes are written first.
- R12: The event level must hold a new value for GLITCH_CYC consecutive clocks before it counts as an edge. Shorter pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| evt_in | input | 1 | Synchronized event level |
| tick_1hz | input | 1 | One-cycle seconds tick |
| now_stamp | input | STAMP_W | Current time/date snapshot |
| trig_sel | input | 2 | Edge select code |
| res_sel | input | 2 | Elapsed-count resolution |
| cmd_arm | input | 1 | Arm for start on first event |
| cmd_start | input | 1 | Start mission now |
| cmd_clear | input | 1 | Clear log and counters |
| cmd_write | input | 1 | Any other register write |
| log_we | output | 1 | Log RAM write enable |
| log_addr | output | ADDR_W | Log RAM byte address |
| log_wdata | output | 8 | Log RAM write data |
| start_stamp | output | STAMP_W | Captured mission start time |
| evt_count | output | CNT_W | Events in current mission |
| etc_value | output | 16 | Live elapsed-time count |
| log_ptr | output | ADDR_W | Next log write address |
| mission_armed | output | 1 | Armed flag |
| mission_active | output | 1 | Mission-in-progress flag |
| mem_cleared | output | 1 | Log cleared, start allowed |

## Verification
The bench builds the block with ADDR_W=4, a 16-byte log holding eight events, so pointer wrap and overwrite of the oldest entry come after a handful of events, and a full clear sweep takes only sixteen cycles. SEC_PER_MIN=3 and MIN_PER_HR=2 bring the minute and hour resolutions within a few ticks. GLITCH_CYC=4 lets a three-cycle pulse be shown to be ignored. Holding the tick high for 65,540 cycles drives the elapsed count into saturation. A stop command placed in the exact cycle an event is captured shows that the two-byte write completes before the mission ends.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
   localparam int ETC_W = 16;

   localparam logic [1:0] TRIG_OFF  = 2'b00;
   localparam logic [1:0] TRIG_FALL = 2'b01;
   localparam logic [1:0] TRIG_RISE = 2'b10;
   localparam logic [1:0] TRIG_BOTH = 2'b11;

   localparam logic [1:0] RES_SEC = 2'd0;
   localparam logic [1:0] RES_MIN = 2'd1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_ARMED,
      ST_RUN,
      ST_WRHI
   } evlog_state_e;
endpackage

// File: rtl/evlog_edge.sv
module evlog_edge #(
   parameter int GLITCH_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt_in,
   input  logic [1:0] trig_sel,
   output logic       trig
);
   logic filt, rise_p, fall_p;

   if (GLITCH_CYC < 1) begin : g_bad_glitch
      $error("evlog_edge: GLITCH_CYC must be at least 1");
   end

   if (GLITCH_CYC == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt   <= 1'b0;
            rise_p <= 1'b0;
            fall_p <= 1'b0;
         end else begin
            filt   <= evt_in;
            rise_p <= evt_in & ~filt;
            fall_p <= ~evt_in & filt;
         end
      end
   end else begin : g_filter
      localparam int CW = $clog2(GLITCH_CYC);
      logic [CW-1:0] run_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            filt    <= 1'b0;
            run_cnt <= '0;
            rise_p  <= 1'b0;
            fall_p  <= 1'b0;
         end else begin
            rise_p <= 1'b0;
            fall_p <= 1'b0;
            if (evt_in == filt) begin
               run_cnt <= '0;
            end else if (run_cnt == CW'(GLITCH_CYC - 1)) begin
               run_cnt <= '0;
               filt    <= evt_in;
               rise_p  <= evt_in;
               fall_p  <= ~evt_in;
            end else begin
               run_cnt <= run_cnt + 1'b1;
            end
         end
      end
   end

   assign trig = (rise_p & trig_sel[1]) | (fall_p & trig_sel[0]);

   // R12: a new filtered level always matches the raw input seen on that edge
   p_filter_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (filt != $past(filt)) |-> ($past(evt_in) == filt));
endmodule

// File: rtl/evlog_etc.sv
module evlog_etc #(
   parameter int SEC_PER_MIN = 60,
   parameter int MIN_PER_HR  = 60
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run,
   input  logic                       restart,
   input  logic                       tick,
   input  logic [1:0]                 res_sel,
   output logic [evlog_pkg::ETC_W-1:0] etc_q
);
   import evlog_pkg::*;

   localparam int SW = $clog2(SEC_PER_MIN);
   localparam int MW = $clog2(MIN_PER_HR);

   if (SEC_PER_MIN < 2 || MIN_PER_HR < 2) begin : g_bad_div
      $error("evlog_etc: dividers must be at least 2");
   end

   logic [SW-1:0] sec_cnt;
   logic [MW-1:0] min_cnt;
   logic          min_tick, hr_tick, step;

   assign min_tick = tick && (sec_cnt == SW'(SEC_PER_MIN - 1));
   assign hr_tick  = min_tick && (min_cnt == MW'(MIN_PER_HR - 1));

   always_comb begin
      case (res_sel)
         RES_SEC: step = tick;
         RES_MIN: step = min_tick;
         default: step = hr_tick;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_cnt <= '0;
         min_cnt <= '0;
         etc_q   <= '0;
      end else if (restart) begin
         sec_cnt <= '0;
         min_cnt <= '0;
         etc_q   <= '0;
      end else if (run) begin
         if (tick)
            sec_cnt <= min_tick ? '0 : sec_cnt + 1'b1;
         if (min_tick)
            min_cnt <= hr_tick ? '0 : min_cnt + 1'b1;
         if (step && (etc_q != '1))
            etc_q <= etc_q + 1'b1;
      end
   end

   // R4: saturated count never wraps
   p_etc_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (etc_q == '1 && !restart) |=> (etc_q == '1));
   // R4: no advance outside a mission
   p_etc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(etc_q));
endmodule

// File: rtl/evlog_ctrl.sv
module evlog_ctrl #(
   parameter int ADDR_W  = 11,
   parameter int CNT_W   = 24,
   parameter int STAMP_W = 64
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        trig,
   input  logic [1:0]                  trig_sel,
   input  logic                        cmd_arm,
   input  logic                        cmd_start,
   input  logic                        cmd_clear,
   input  logic                        cmd_write,
   input  logic [STAMP_W-1:0]          now_stamp,
   input  logic [evlog_pkg::ETC_W-1:0] etc_val,
   output logic                        etc_restart,
   output logic                        log_we,
   output logic [ADDR_W-1:0]           log_addr,
   output logic [7:0]                  log_wdata,
   output logic [STAMP_W-1:0]          stamp_q,
   output logic [CNT_W-1:0]            ev_count,
   output logic [ADDR_W-1:0]           ptr_q,
   output logic                        me_q,
   output logic                        mip_q,
   output logic                        mem_clr_q
);
   import evlog_pkg::*;

   evlog_state_e  state;
   logic [ADDR_W-1:0] clr_addr;
   logic [7:0]        hi_q;
   logic              stop_pend;
   logic              start_ok;

   assign start_ok = mem_clr_q && (trig_sel != TRIG_OFF);

   always_comb begin
      case (state)
         ST_IDLE:  etc_restart = cmd_clear || (cmd_start && start_ok);
         ST_ARMED: etc_restart = !cmd_write && (cmd_start || trig);
         ST_RUN:   etc_restart = trig;
         default:  etc_restart = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         clr_addr  <= '0;
         hi_q      <= '0;
         stop_pend <= 1'b0;
         log_we    <= 1'b0;
         log_addr  <= '0;
         log_wdata <= '0;
         stamp_q   <= '0;
         ev_count  <= '0;
         ptr_q     <= '0;
         me_q      <= 1'b0;
         mip_q     <= 1'b0;
         mem_clr_q <= 1'b0;
      end else begin
         log_we <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (cmd_clear) begin
                  state     <= ST_CLEAR;
                  clr_addr  <= '0;
                  ev_count  <= '0;
                  ptr_q     <= '0;
                  stamp_q   <= '0;
                  mem_clr_q <= 1'b0;
               end else if (cmd_start && start_ok) begin
                  me_q     <= 1'b1;
                  mip_q    <= 1'b1;
                  stamp_q  <= now_stamp;
                  ev_count <= CNT_W'(1);
                  state    <= ST_RUN;
               end else if (cmd_arm && start_ok) begin
                  me_q  <= 1'b1;
                  state <= ST_ARMED;
               end
            end
            ST_CLEAR: begin
               log_we    <= 1'b1;
               log_addr  <= clr_addr;
               log_wdata <= 8'h00;
               clr_addr  <= clr_addr + 1'b1;
               if (clr_addr == '1) begin
                  mem_clr_q <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            ST_ARMED: begin
               if (cmd_write) begin
                  me_q  <= 1'b0;
                  state <= ST_IDLE;
               end else if (cmd_start || trig) begin
                  mip_q    <= 1'b1;
                  stamp_q  <= now_stamp;
                  ev_count <= CNT_W'(1);
                  state    <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (trig) begin
                  log_we    <= 1'b1;
                  log_addr  <= ptr_q;
                  log_wdata <= etc_val[7:0];
                  hi_q      <= etc_val[15:8];
                  ev_count  <= ev_count + 1'b1;
                  stop_pend <= cmd_write;
                  state     <= ST_WRHI;
               end else if (cmd_write) begin
                  me_q  <= 1'b0;
                  mip_q <= 1'b0;
                  state <= ST_IDLE;
               end
            end
            ST_WRHI: begin
               log_we    <= 1'b1;
               log_addr  <= ptr_q + 1'b1;
               log_wdata <= hi_q;
               ptr_q     <= ptr_q + 2'd2;
               mem_clr_q <= 1'b0;
               stop_pend <= 1'b0;
               if (stop_pend || cmd_write) begin
                  me_q  <= 1'b0;
                  mip_q <= 1'b0;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_RUN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R8: active implies armed
   p_active_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mip_q |-> me_q);
   // R9: arming only out of a cleared log
   p_start_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(me_q) |-> $past(mem_clr_q));
   // R7: nothing is logged while merely armed
   p_armed_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (me_q && !mip_q) |-> !log_we);
   // R5: low byte is followed by high byte at the next address
   p_byte_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (log_we && mip_q && !log_addr[0]) |=> (log_we && log_addr == $past(log_addr) + 1'b1));
   // R11: mission never ends between the two bytes of an entry
   p_stop_whole_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mip_q) |-> !(log_we && !log_addr[0]));
endmodule

// File: rtl/evt_elapsed_logger.sv
module evt_elapsed_logger #(
   parameter int ADDR_W      = 11,
   parameter int CNT_W       = 24,
   parameter int STAMP_W     = 64,
   parameter int SEC_PER_MIN = 60,
   parameter int MIN_PER_HR  = 60,
   parameter int GLITCH_CYC  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_in,
   input  logic               tick_1hz,
   input  logic [STAMP_W-1:0] now_stamp,
   input  logic [1:0]         trig_sel,
   input  logic [1:0]         res_sel,
   input  logic               cmd_arm,
   input  logic               cmd_start,
   input  logic               cmd_clear,
   input  logic               cmd_write,
   output logic               log_we,
   output logic [ADDR_W-1:0]  log_addr,
   output logic [7:0]         log_wdata,
   output logic [STAMP_W-1:0] start_stamp,
   output logic [CNT_W-1:0]   evt_count,
   output logic [15:0]        etc_value,
   output logic [ADDR_W-1:0]  log_ptr,
   output logic               mission_armed,
   output logic               mission_active,
   output logic               mem_cleared
);
   import evlog_pkg::*;

   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
      $error("evt_elapsed_logger: ADDR_W out of range");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("evt_elapsed_logger: CNT_W too small");
   end

   logic trig, etc_restart;

   evlog_edge #(.GLITCH_CYC(GLITCH_CYC)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   (evt_in),
      .trig_sel (trig_sel),
      .trig     (trig)
   );

   evlog_etc #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_HR(MIN_PER_HR)) u_etc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (mission_active),
      .restart (etc_restart),
      .tick    (tick_1hz),
      .res_sel (res_sel),
      .etc_q   (etc_value)
   );

   evlog_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STAMP_W(STAMP_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig        (trig),
      .trig_sel    (trig_sel),
      .cmd_arm     (cmd_arm),
      .cmd_start   (cmd_start),
      .cmd_clear   (cmd_clear),
      .cmd_write   (cmd_write),
      .now_stamp   (now_stamp),
      .etc_val     (etc_value),
      .etc_restart (etc_restart),
      .log_we      (log_we),
      .log_addr    (log_addr),
      .log_wdata   (log_wdata),
      .stamp_q     (start_stamp),
      .ev_count    (evt_count),
      .ptr_q       (log_ptr),
      .me_q        (mission_armed),
      .mip_q       (mission_active),
      .mem_clr_q   (mem_cleared)
   );
endmodule

// File: tb/evt_elapsed_logger_bench.sv
`timescale 1ns/1ps
module evt_elapsed_logger_bench;
   localparam int ADDR_W = 4;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam logic [63:0] STAMP_A = 64'h2024_0315_1230_4501;
   localparam logic [63:0] STAMP_B = 64'h2031_1122_0807_0602;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic evt_in = 1'b0, tick_1hz = 1'b0;
   logic [63:0] now_stamp = 64'h0;
   logic [1:0] trig_sel = 2'b01, res_sel = 2'd0;
   logic cmd_arm = 1'b0, cmd_start = 1'b0, cmd_clear = 1'b0, cmd_write = 1'b0;
   logic log_we;
   logic [ADDR_W-1:0] log_addr, log_ptr;
   logic [7:0] log_wdata;
   logic [63:0] start_stamp;
   logic [23:0] evt_count;
   logic [15:0] etc_value;
   logic mission_armed, mission_active, mem_cleared;

   int checks = 0, errors = 0, wcount = 0;
   bit done = 0;
   logic [7:0] shadow [DEPTH];

   always #2.5 clk = ~clk;

   evt_elapsed_logger #(.ADDR_W(ADDR_W), .CNT_W(24), .STAMP_W(64),
      .SEC_PER_MIN(3), .MIN_PER_HR(2), .GLITCH_CYC(4)) u_evt_elapsed_logger (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .tick_1hz(tick_1hz),
      .now_stamp(now_stamp), .trig_sel(trig_sel), .res_sel(res_sel),
      .cmd_arm(cmd_arm), .cmd_start(cmd_start), .cmd_clear(cmd_clear),
      .cmd_write(cmd_write), .log_we(log_we), .log_addr(log_addr),
      .log_wdata(log_wdata), .start_stamp(start_stamp), .evt_count(evt_count),
      .etc_value(etc_value), .log_ptr(log_ptr), .mission_armed(mission_armed),
      .mission_active(mission_active), .mem_cleared(mem_cleared));

   always @(posedge clk) begin
      if (rst_n && log_we) begin
         shadow[log_addr] <= log_wdata;
         wcount <= wcount + 1;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic set_evt(input logic v);
      @(negedge clk) evt_in = v;
      repeat (8) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick_1hz = 1'b1;
         @(negedge clk) tick_1hz = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic strobe(input int which);
      @(negedge clk);
      case (which)
         0: cmd_arm = 1'b1;
         1: cmd_start = 1'b1;
         2: cmd_clear = 1'b1;
         default: cmd_write = 1'b1;
      endcase
      @(negedge clk);
      cmd_arm = 1'b0; cmd_start = 1'b0; cmd_clear = 1'b0; cmd_write = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic do_clear();
      strobe(2);
      repeat (DEPTH + 4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("reset armed", mission_armed, 0);
      chk("reset active", mission_active, 0);
      chk("R9 reset mem_cleared", mem_cleared, 0);
      chk("reset count", evt_count, 0);
      chk("reset ptr", log_ptr, 0);
      chk("reset etc", etc_value, 0);
   endtask

   task automatic t_refuse_uncleared();
      trig_sel = 2'b01;
      strobe(0);
      chk("R9 arm refused uncleared", mission_armed, 0);
      strobe(1);
      chk("R9 start refused uncleared", mission_active, 0);
   endtask

   task automatic t_clear();
      int w0;
      bit allz;
      for (int i = 0; i < DEPTH; i++) shadow[i] = 8'hAA;
      w0 = wcount;
      do_clear();
      allz = 1;
      for (int i = 0; i < DEPTH; i++) if (shadow[i] !== 8'h00) allz = 0;
      chk("R10 log zeroed", allz, 1);
      chk("R10 sweep writes", wcount - w0, DEPTH);
      chk("R10 mem_cleared set", mem_cleared, 1);
      chk("R10 count zero", evt_count, 0);
   endtask

   task automatic t_illegal_code();
      trig_sel = 2'b00;
      strobe(0);
      chk("R2 arm refused", mission_armed, 0);
      strobe(1);
      chk("R2 start refused", mission_active, 0);
      set_evt(1); set_evt(0);
      chk("R2 toggles ignored", evt_count, 0);
   endtask

   task automatic t_delayed();
      int w0;
      trig_sel = 2'b01; res_sel = 2'd0; now_stamp = STAMP_A;
      strobe(0);
      chk("R7 armed", mission_armed, 1);
      chk("R7 not active", mission_active, 0);
      ticks(3);
      chk("R4 no count while armed", etc_value, 0);
      set_evt(1);
      chk("R1 rise ignored on fall code", mission_active, 0);
      w0 = wcount;
      set_evt(0);
      chk("R7 active on first event", mission_active, 1);
      chk("R7 count one", evt_count, 1);
      chk("R7 stamp", start_stamp, STAMP_A);
      chk("R7 no log write", wcount - w0, 0);
      ticks(5);
      chk("R3 seconds resolution", etc_value, 5);
      set_evt(1);
      chk("R1 rise ignored in mission", evt_count, 1);
      set_evt(0);
      chk("R5 low byte", shadow[0], 8'd5);
      chk("R5 high byte", shadow[1], 8'd0);
      chk("R5 ptr", log_ptr, 2);
      chk("R5 count", evt_count, 2);
      chk("R5 etc cleared", etc_value, 0);
      chk("R10 mem_cleared drops", mem_cleared, 0);
      @(negedge clk) evt_in = 1'b1;
      repeat (3) @(negedge clk);
      evt_in = 1'b0;
      repeat (8) @(negedge clk);
      chk("R12 short pulse ignored", evt_count, 2);
   endtask

   task automatic t_stop_during_event();
      ticks(3);
      set_evt(1);
      @(negedge clk) evt_in = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk) cmd_write = 1'b1;
      @(negedge clk) cmd_write = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 low byte done", shadow[2], 8'd3);
      chk("R11 high byte done", shadow[3], 8'd0);
      chk("R11 ptr advanced", log_ptr, 4);
      chk("R11 count", evt_count, 3);
      chk("R11 active dropped", mission_active, 0);
      chk("R11 armed dropped", mission_armed, 0);
      strobe(0);
      chk("R9 rearm refused after mission", mission_armed, 0);
   endtask

   task automatic t_immediate();
      int w0;
      logic lvl;
      trig_sel = 2'b10; res_sel = 2'd1;
      do_clear();
      chk("R10 cleared again", mem_cleared, 1);
      now_stamp = STAMP_B;
      strobe(1);
      chk("R8 armed", mission_armed, 1);
      chk("R8 active", mission_active, 1);
      chk("R8 count", evt_count, 1);
      chk("R8 stamp", start_stamp, STAMP_B);
      ticks(7);
      chk("R3 minute resolution", etc_value, 2);
      set_evt(1);
      chk("R8 first interval lo", shadow[0], 8'd2);
      chk("R8 first interval hi", shadow[1], 8'd0);
      chk("R8 count", evt_count, 2);
      set_evt(0);
      chk("R1 fall ignored on rise code", evt_count, 2);
      res_sel = 2'd2;
      ticks(13);
      chk("R3 hour resolution", etc_value, 2);
      set_evt(1);
      chk("R3 hour entry", shadow[2], 8'd2);
      chk("R5 ptr", log_ptr, 4);
      set_evt(0);
      w0 = wcount;
      strobe(2);
      repeat (20) @(negedge clk);
      chk("R10 clear ignored in mission", wcount - w0, 0);
      chk("R10 mission kept", mission_active, 1);
      res_sel = 2'd0;
      @(negedge clk) tick_1hz = 1'b1;
      repeat (65540) @(negedge clk);
      tick_1hz = 1'b0;
      @(negedge clk);
      chk("R4 saturates", etc_value, 16'hFFFF);
      set_evt(1);
      chk("R4 saturated lo", shadow[4], 8'hFF);
      chk("R4 saturated hi", shadow[5], 8'hFF);
      trig_sel = 2'b11;
      set_evt(0);
      chk("R1 both edges fall", evt_count, 5);
      chk("R1 ptr", log_ptr, 8);
      lvl = 1'b0;
      for (int i = 0; i < 5; i++) begin
         ticks(i + 1);
         lvl = ~lvl;
         set_evt(lvl);
         if (i == 3) chk("R6 pointer wrapped", log_ptr, 0);
      end
      chk("R6 oldest overwritten", shadow[0], 8'd5);
      chk("R6 ptr after wrap", log_ptr, 2);
      chk("R1 both edges count", evt_count, 10);
      strobe(3);
      chk("R11 stop active", mission_active, 0);
      chk("R11 stop armed", mission_armed, 0);
      ticks(2);
      chk("R4 idle no count", etc_value, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_refuse_uncleared();
      t_clear();
      t_illegal_code();
      t_delayed();
      t_stop_during_event();
      t_immediate();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule